// File: doc/BRIEF.md
# EPROM Byte Programming Sequencer

This block sits on the host side of a parallel UV-erasable EPROM and burns a run of bytes into it. A single start command supplies a base address and a byte count. The sequencer then raises its programming-voltage request. For each byte it fetches one value from a data source, places address and data on the EPROM buses, and fires one program pulse on the chip-enable/program line. It then turns the data bus around and reads the location back to check it.

All timing is counted in clock cycles, and each interval is a parameter. With a 50 MHz clock the defaults give 2 µs setup and hold windows and a 50 ms pulse. The verify read holds output enable low long enough to cover the part's 120 ns access time. After a read the bus is left floating long enough to cover the part's 100 ns release time. A byte that reads back wrong stops the run and latches its address. A run that completes, or fails, ends with a one-cycle done pulse.

The data source shows the next byte on `src_data` combinationally and advances when `src_rd` is high at a clock edge. The EPROM data bus is split into an output value, a drive enable and an input value. The board's three-state pad joins them.

Top module: `eprom_prog_seq`

## Requirements
- R1: Out of reset, and whenever the block is idle, the outputs are as follows. `vpp_req`=0, `ep_ce_pgm`=1 (standby), `ep_oe_n`=1, `ep_dq_drive`=0, `src_rd`=0, `done`=0 and `busy`=0.
- R2: A start with a nonzero count clears `fail`. It raises `vpp_req` for VPP_CYC cycles before the first byte is fetched. `vpp_req` stays high from then until the done cycle, and is high in every pulse cycle.
- R3: Each byte begins with a one-cycle fetch: `src_rd`=1 with the data bus undriven. Byte i goes to address base+i, modulo 2^ADDR_W.
- R4: During the SETUP_CYC cycles before the pulse rises, several outputs are held steady. The address and data are stable, the data bus is driven, `ep_oe_n`=1 and `ep_ce_pgm`=0.
- R5: The program pulse (`ep_ce_pgm`=1 while the data bus is driven) lasts exactly PULSE_CYC cycles and never longer.
- R6: The data bus is driven, with the address unchanged, for HOLD_CYC cycles after the pulse falls. The bus is then released for TURN_CYC cycles. `ep_oe_n` stays high for at least HOLD_CYC+TURN_CYC cycles after the fall.
- R7: The verify read holds `ep_oe_n`=0 for VERIFY_CYC cycles, with the bus undriven. `ep_dq_in` is compared with the written byte at the last of these cycles. The bus is never driven while `ep_oe_n`=0. After a good byte that is not the last one, `ep_oe_n` is high for FLOAT_CYC cycles with the next address before the next fetch.
- R8: When a byte reads back wrong, the run stops. In the next cycle `done`=1, `vpp_req`=0, `fail`=1 and `fail_addr` holds the failing address. No further byte is fetched.
- R9: After the last byte verifies, there is one cycle with `done`=1, `vpp_req`=0 and `fail`=0. The block then returns to idle.
- R10: A start with a count of 0 gives `done`=1 in the next cycle. No voltage request, no fetch and no pulse take place.
- R11: `start` is ignored while `busy`=1.
- R12: `fail` and `fail_addr` keep their values until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin a run (taken only when idle) |
| base_addr | input | ADDR_W | First EPROM address |
| byte_count | input | ADDR_W+1 | Number of bytes to program |
| src_rd | output | 1 | Consume the byte on src_data |
| src_data | input | DATA_W | Next byte from the data source |
| ep_addr | output | ADDR_W | EPROM address bus |
| ep_dq_out | output | DATA_W | Value to drive on the EPROM data bus |
| ep_dq_drive | output | 1 | Data bus drive enable |
| ep_dq_in | input | DATA_W | Value read from the EPROM data bus |
| ep_oe_n | output | 1 | EPROM output enable, active low |
| ep_ce_pgm | output | 1 | EPROM chip enable / program pulse |
| vpp_req | output | 1 | Request for the programming supply |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| fail | output | 1 | Last run stopped on a verify mismatch |
| fail_addr | output | ADDR_W | Address of the mismatching byte |

## Verification
The bench targets several corner cases, each with a visible symptom if the design gets it wrong.

- A stuck bit in the middle of a run must stop the sequencer at exactly that address. A design that advanced the address before capturing it would report the neighbour. A design that kept going would fetch extra bytes.
- Rewriting a location with all-ones over zeros must fail. EPROM bits cannot return to one, so a compare taken before the bus turnaround, against the driven value, would wrongly pass.
- A zero count must finish at once with no pulse.
- A start pulsed mid-run must leave the run untouched.
- A run crossing the top address must wrap.
- An off-by-one in any interval counter shows up as a pulse, hold or setup phase one cycle short or long against the per-cycle model.

// File: rtl/pgm_pkg.sv
`timescale 1ns/1ps
package pgm_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_VPP,
        ST_LOAD,
        ST_SETUP,
        ST_PULSE,
        ST_HOLD,
        ST_TURN,
        ST_VERIFY,
        ST_FLOAT,
        ST_DONE
    } pgm_state_e;

    typedef struct packed {
        logic vpp;
        logic ce;
        logic oe_n;
        logic drive;
        logic fetch;
        logic done;
    } pgm_pins_t;

    function automatic int unsigned max2(int unsigned a, int unsigned b);
        return (a > b) ? a : b;
    endfunction

    // Pin levels for each phase of the sequence
    function automatic pgm_pins_t pins_for(pgm_state_e s);
        pgm_pins_t p;
        p = '{vpp: 1'b1, ce: 1'b0, oe_n: 1'b1, drive: 1'b0, fetch: 1'b0, done: 1'b0};
        unique case (s)
            ST_IDLE:   begin p.vpp = 1'b0; p.ce = 1'b1; end
            ST_VPP:    ;
            ST_LOAD:   p.fetch = 1'b1;
            ST_SETUP:  p.drive = 1'b1;
            ST_PULSE:  begin p.drive = 1'b1; p.ce = 1'b1; end
            ST_HOLD:   p.drive = 1'b1;
            ST_TURN:   ;
            ST_VERIFY: p.oe_n = 1'b0;
            ST_FLOAT:  ;
            ST_DONE:   begin p.vpp = 1'b0; p.ce = 1'b1; p.done = 1'b1; end
            default:   ;
        endcase
        return p;
    endfunction

endpackage

// File: rtl/pgm_timer.sv
`timescale 1ns/1ps
module pgm_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)              cnt <= '0;
        else if (load)        cnt <= load_val;
        else if (cnt != '0)   cnt <= cnt - 1'b1;
    end

    assign expired = (cnt == '0);
endmodule

// File: rtl/pgm_track.sv
`timescale 1ns/1ps
module pgm_track #(
    parameter int ADDR_W = 11,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              begin_run,
    input  logic [ADDR_W-1:0] base_addr,
    input  logic [ADDR_W:0]   byte_count,
    input  logic              fetch,
    input  logic [DATA_W-1:0] src_data,
    input  logic              advance,
    input  logic              record,
    input  logic [DATA_W-1:0] rd_data,
    output logic [ADDR_W-1:0] addr,
    output logic [DATA_W-1:0] wdata,
    output logic              last,
    output logic              mismatch,
    output logic              fail,
    output logic [ADDR_W-1:0] fail_addr
);
    logic [ADDR_W:0] remain;

    always_ff @(posedge clk) begin
        if (rst) begin
            addr      <= '0;
            remain    <= '0;
            wdata     <= '0;
            fail      <= 1'b0;
            fail_addr <= '0;
        end else begin
            if (begin_run) begin
                addr   <= base_addr;
                remain <= byte_count;
                fail   <= 1'b0;
            end
            if (fetch)   wdata <= src_data;
            if (advance) begin
                addr   <= addr + 1'b1;
                remain <= remain - 1'b1;
            end
            if (record) begin
                fail      <= 1'b1;
                fail_addr <= addr;
            end
        end
    end

    assign last     = (remain == {{ADDR_W{1'b0}}, 1'b1});
    assign mismatch = (rd_data != wdata);
endmodule

// File: rtl/eprom_prog_seq.sv
`timescale 1ns/1ps
module eprom_prog_seq
    import pgm_pkg::*;
#(
    parameter int ADDR_W     = 11,
    parameter int DATA_W     = 8,
    parameter int VPP_CYC    = 100,
    parameter int SETUP_CYC  = 100,
    parameter int PULSE_CYC  = 2_500_000,
    parameter int HOLD_CYC   = 100,
    parameter int TURN_CYC   = 2,
    parameter int VERIFY_CYC = 8,
    parameter int FLOAT_CYC  = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [ADDR_W-1:0] base_addr,
    input  logic [ADDR_W:0]   byte_count,
    output logic              src_rd,
    input  logic [DATA_W-1:0] src_data,
    output logic [ADDR_W-1:0] ep_addr,
    output logic [DATA_W-1:0] ep_dq_out,
    output logic              ep_dq_drive,
    input  logic [DATA_W-1:0] ep_dq_in,
    output logic              ep_oe_n,
    output logic              ep_ce_pgm,
    output logic              vpp_req,
    output logic              busy,
    output logic              done,
    output logic              fail,
    output logic [ADDR_W-1:0] fail_addr
);
    localparam int unsigned MAX_A   = max2(max2(VPP_CYC, SETUP_CYC), max2(PULSE_CYC, HOLD_CYC));
    localparam int unsigned MAX_B   = max2(max2(TURN_CYC, VERIFY_CYC), FLOAT_CYC);
    localparam int unsigned MAX_CYC = max2(MAX_A, MAX_B);
    localparam int          CNT_W   = $clog2(MAX_CYC + 1);

    pgm_state_e       st, nxt;
    pgm_pins_t        pins;
    logic             tmr_zero, tmr_load;
    logic [CNT_W-1:0] tmr_val;
    logic             trk_begin, trk_adv, trk_rec;
    logic             last, mismatch;

    function automatic logic [CNT_W-1:0] span_of(pgm_state_e s);
        unique case (s)
            ST_VPP:    return CNT_W'(VPP_CYC - 1);
            ST_SETUP:  return CNT_W'(SETUP_CYC - 1);
            ST_PULSE:  return CNT_W'(PULSE_CYC - 1);
            ST_HOLD:   return CNT_W'(HOLD_CYC - 1);
            ST_TURN:   return CNT_W'(TURN_CYC - 1);
            ST_VERIFY: return CNT_W'(VERIFY_CYC - 1);
            ST_FLOAT:  return CNT_W'(FLOAT_CYC - 1);
            default:   return '0;
        endcase
    endfunction

    always_comb begin
        nxt       = st;
        trk_begin = 1'b0;
        trk_adv   = 1'b0;
        trk_rec   = 1'b0;
        unique case (st)
            ST_IDLE: if (start) begin
                trk_begin = 1'b1;
                nxt = (byte_count == '0) ? ST_DONE : ST_VPP;
            end
            ST_VPP:    if (tmr_zero) nxt = ST_LOAD;
            ST_LOAD:   nxt = ST_SETUP;
            ST_SETUP:  if (tmr_zero) nxt = ST_PULSE;
            ST_PULSE:  if (tmr_zero) nxt = ST_HOLD;
            ST_HOLD:   if (tmr_zero) nxt = ST_TURN;
            ST_TURN:   if (tmr_zero) nxt = ST_VERIFY;
            ST_VERIFY: if (tmr_zero) begin
                if (mismatch) begin
                    trk_rec = 1'b1;
                    nxt = ST_DONE;
                end else if (last) begin
                    nxt = ST_DONE;
                end else begin
                    trk_adv = 1'b1;
                    nxt = ST_FLOAT;
                end
            end
            ST_FLOAT:  if (tmr_zero) nxt = ST_LOAD;
            ST_DONE:   nxt = ST_IDLE;
            default:   nxt = ST_IDLE;
        endcase
        tmr_load = (nxt != st);
        tmr_val  = span_of(nxt);
    end

    always_ff @(posedge clk) begin
        if (rst) st <= ST_IDLE;
        else     st <= nxt;
    end

    pgm_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_zero)
    );

    pgm_track #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_track (
        .clk        (clk),
        .rst        (rst),
        .begin_run  (trk_begin),
        .base_addr  (base_addr),
        .byte_count (byte_count),
        .fetch      (pins.fetch),
        .src_data   (src_data),
        .advance    (trk_adv),
        .record     (trk_rec),
        .rd_data    (ep_dq_in),
        .addr       (ep_addr),
        .wdata      (ep_dq_out),
        .last       (last),
        .mismatch   (mismatch),
        .fail       (fail),
        .fail_addr  (fail_addr)
    );

    assign pins        = pins_for(st);
    assign src_rd      = pins.fetch;
    assign ep_dq_drive = pins.drive;
    assign ep_oe_n     = pins.oe_n;
    assign ep_ce_pgm   = pins.ce;
    assign vpp_req     = pins.vpp;
    assign done        = pins.done;
    assign busy        = (st != ST_IDLE);
endmodule

// File: rtl/eprom_prog_seq_chk.sv
`timescale 1ns/1ps
module eprom_prog_seq_chk #(
    parameter int ADDR_W    = 11,
    parameter int DATA_W    = 8,
    parameter int SETUP_CYC = 100,
    parameter int PULSE_CYC = 2_500_000,
    parameter int HOLD_CYC  = 100,
    parameter int TURN_CYC  = 2
) (
    input logic              clk,
    input logic              rst,
    input logic              ep_ce_pgm,
    input logic              ep_dq_drive,
    input logic              ep_oe_n,
    input logic [ADDR_W-1:0] ep_addr,
    input logic [DATA_W-1:0] ep_dq_out,
    input logic              vpp_req,
    input logic              done,
    input logic              fail,
    input logic [ADDR_W-1:0] fail_addr
);
    localparam int POST_CAP = HOLD_CYC + TURN_CYC;

    logic [ADDR_W-1:0] prev_addr;
    logic [DATA_W-1:0] prev_dq;
    int                quiet, hi_cnt, post_cnt;
    logic              armed;
    logic              pulsing, setup_ok;

    assign pulsing  = ep_ce_pgm && ep_dq_drive;
    assign setup_ok = ep_dq_drive && ep_oe_n && !ep_ce_pgm;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_addr <= '0;
            prev_dq   <= '0;
            quiet     <= 0;
            hi_cnt    <= 0;
            post_cnt  <= 0;
            armed     <= 1'b0;
        end else begin
            prev_addr <= ep_addr;
            prev_dq   <= ep_dq_out;
            if (!setup_ok)                                        quiet <= 0;
            else if (ep_addr != prev_addr || ep_dq_out != prev_dq) quiet <= 1;
            else if (quiet < SETUP_CYC)                           quiet <= quiet + 1;
            if (!pulsing)                   hi_cnt <= 0;
            else if (hi_cnt <= PULSE_CYC)   hi_cnt <= hi_cnt + 1;
            if (pulsing) begin
                armed    <= 1'b1;
                post_cnt <= 0;
            end else if (armed && post_cnt < POST_CAP) begin
                post_cnt <= post_cnt + 1;
            end
        end
    end

    p_setup_window_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(ep_ce_pgm) && ep_dq_drive |-> quiet >= SETUP_CYC);

    p_pulse_max_r5: assert property (@(posedge clk) disable iff (rst)
        hi_cnt <= PULSE_CYC);

    p_pulse_len_r5: assert property (@(posedge clk) disable iff (rst)
        $fell(ep_ce_pgm) && ep_dq_drive |-> hi_cnt == PULSE_CYC);

    p_addr_hold_r6: assert property (@(posedge clk) disable iff (rst)
        pulsing |=> $stable(ep_addr));

    p_data_hold_r6: assert property (@(posedge clk) disable iff (rst)
        armed && $fell(ep_dq_drive) |-> post_cnt >= HOLD_CYC);

    p_oe_after_pulse_r6: assert property (@(posedge clk) disable iff (rst)
        armed && !ep_oe_n |-> post_cnt >= POST_CAP);

    p_no_contention_r7: assert property (@(posedge clk) disable iff (rst)
        !(ep_dq_drive && !ep_oe_n));

    p_vpp_in_pulse_r2: assert property (@(posedge clk) disable iff (rst)
        pulsing |-> vpp_req);

    p_done_single_r9: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    p_fail_addr_kept_r12: assert property (@(posedge clk) disable iff (rst)
        fail && $past(fail) |-> $stable(fail_addr));
endmodule

bind eprom_prog_seq eprom_prog_seq_chk #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .SETUP_CYC (SETUP_CYC),
    .PULSE_CYC (PULSE_CYC),
    .HOLD_CYC  (HOLD_CYC),
    .TURN_CYC  (TURN_CYC)
) i_chk (
    .clk         (clk),
    .rst         (rst),
    .ep_ce_pgm   (ep_ce_pgm),
    .ep_dq_drive (ep_dq_drive),
    .ep_oe_n     (ep_oe_n),
    .ep_addr     (ep_addr),
    .ep_dq_out   (ep_dq_out),
    .vpp_req     (vpp_req),
    .done        (done),
    .fail        (fail),
    .fail_addr   (fail_addr)
);

// File: tb/test_eprom_prog_seq.sv
`timescale 1ns/1ps
module test_eprom_prog_seq;
    localparam int VPP_C = 4;
    localparam int SET_C = 3;
    localparam int PUL_C = 6;
    localparam int HLD_C = 3;
    localparam int TRN_C = 2;
    localparam int VER_C = 2;
    localparam int FLT_C = 2;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start = 1'b0;
    logic [7:0] base_addr = '0;
    logic [8:0] byte_count = '0;
    logic       src_rd;
    logic [7:0] src_data;
    logic [7:0] ep_addr, ep_dq_out, ep_dq_in, fail_addr;
    logic       ep_dq_drive, ep_oe_n, ep_ce_pgm, vpp_req, busy, done, fail;

    always #10 clk = ~clk;

    eprom_prog_seq #(
        .ADDR_W(8), .DATA_W(8), .VPP_CYC(VPP_C), .SETUP_CYC(SET_C), .PULSE_CYC(PUL_C),
        .HOLD_CYC(HLD_C), .TURN_CYC(TRN_C), .VERIFY_CYC(VER_C), .FLOAT_CYC(FLT_C)
    ) i_eprom_prog_seq (
        .clk(clk), .rst(rst), .start(start), .base_addr(base_addr), .byte_count(byte_count),
        .src_rd(src_rd), .src_data(src_data), .ep_addr(ep_addr), .ep_dq_out(ep_dq_out),
        .ep_dq_drive(ep_dq_drive), .ep_dq_in(ep_dq_in), .ep_oe_n(ep_oe_n), .ep_ce_pgm(ep_ce_pgm),
        .vpp_req(vpp_req), .busy(busy), .done(done), .fail(fail), .fail_addr(fail_addr)
    );

    // Data source
    logic [7:0] src_mem [0:63];
    int         src_idx;
    always @(posedge clk) begin
        if (rst)         src_idx <= 0;
        else if (src_rd) src_idx <= src_idx + 1;
    end
    assign src_data = src_mem[src_idx[5:0]];

    // EPROM part: erased to ones, a fall of the pulse clears bits, stuck bits stay at one
    logic [7:0] part_mem [0:255];
    logic [7:0] stuck    [0:255];
    logic       pend;
    always @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < 256; k++) part_mem[k] <= 8'hFF;
            pend <= 1'b0;
        end else if (ep_ce_pgm && ep_dq_drive) begin
            pend <= 1'b1;
        end else if (pend && !ep_ce_pgm) begin
            if (vpp_req) part_mem[ep_addr] <= part_mem[ep_addr] & (ep_dq_out | stuck[ep_addr]);
            pend <= 1'b0;
        end
    end
    assign ep_dq_in = (!ep_ce_pgm && !ep_oe_n && !ep_dq_drive) ? part_mem[ep_addr] : 8'hFF;

    // Reference model
    typedef struct packed {
        logic vpp, ce, oe_n, drv, src, dn, bsy, fl;
        logic [7:0] addr, dq, faddr;
    } obs_t;

    obs_t       exp_q[$];
    string      tag_q[$];
    logic [7:0] shadow [0:255];
    logic       exp_fail = 1'b0;
    logic [7:0] exp_faddr = '0;
    int         exp_fetch = 0;
    string      idle_tag = "R1";
    int         tests = 0, fails = 0;
    bit         finished = 0;

    task automatic push(input logic v, c, o, d, s, dn, b, f,
                        input logic [7:0] a, dq, fa, input string t, input int reps);
        for (int r = 0; r < reps; r++) begin
            exp_q.push_back('{v, c, o, d, s, dn, b, f, a, dq, fa});
            tag_q.push_back(t);
        end
    endtask

    task automatic model_job(input logic [7:0] base, input int n);
        logic [7:0] a, d, rd;
        exp_fail = 1'b0;
        if (n == 0) begin
            push(0,1,1,0,0,1,1,0, base, 8'h00, 8'h00, "R10", 1);
            return;
        end
        push(1,0,1,0,0,0,1,0, base, 8'h00, 8'h00, "R2", VPP_C);
        for (int i = 0; i < n; i++) begin
            a = base + 8'(i);
            d = src_mem[exp_fetch];
            exp_fetch++;
            push(1,0,1,0,1,0,1,0, a, 8'h00, 8'h00, "R3", 1);
            push(1,0,1,1,0,0,1,0, a, d, 8'h00, "R4", SET_C);
            push(1,1,1,1,0,0,1,0, a, d, 8'h00, "R5", PUL_C);
            push(1,0,1,1,0,0,1,0, a, d, 8'h00, "R6", HLD_C);
            push(1,0,1,0,0,0,1,0, a, 8'h00, 8'h00, "R6", TRN_C);
            push(1,0,0,0,0,0,1,0, a, 8'h00, 8'h00, "R7", VER_C);
            rd = shadow[a] & (d | stuck[a]);
            shadow[a] = rd;
            if (rd != d) begin
                exp_fail  = 1'b1;
                exp_faddr = a;
                push(0,1,1,0,0,1,1,1, a, 8'h00, a, "R8", 1);
                return;
            end
            if (i == n - 1) begin
                push(0,1,1,0,0,1,1,0, a, 8'h00, 8'h00, "R9", 1);
                return;
            end
            push(1,0,1,0,0,0,1,0, a + 8'd1, 8'h00, 8'h00, "R7", FLT_C);
        end
    endtask

    task automatic tick();
        obs_t  e, act;
        string t;
        @(negedge clk);
        if (exp_q.size() > 0) begin
            e = exp_q.pop_front();
            t = tag_q.pop_front();
        end else begin
            e = '{1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, exp_fail, 8'h00, 8'h00, exp_faddr};
            t = idle_tag;
        end
        act = '{vpp_req, ep_ce_pgm, ep_oe_n, ep_dq_drive, src_rd, done, busy, fail,
                e.bsy ? ep_addr : e.addr, e.drv ? ep_dq_out : e.dq, e.fl ? fail_addr : e.faddr};
        tests++;
        if (act !== e) begin
            fails++;
            $display("FAIL %s: actual=%h expected=%h", t, act, e);
        end
    endtask

    task automatic run_job(input logic [7:0] base, input int n, input int ign_at);
        int k;
        tick();
        start = 1'b1; base_addr = base; byte_count = 9'(n);
        model_job(base, n);
        tick();
        start = 1'b0;
        k = 0;
        while (exp_q.size() > 0) begin
            tick();
            k++;
            if (k == ign_at) begin
                start = 1'b1; base_addr = ~base; byte_count = 9'd3;   // R11: must be ignored
            end else begin
                start = 1'b0;
            end
        end
        start = 1'b0;
        repeat (3) tick();
        tests++;   // R3 and R11: fetch count matches the model exactly
        if (src_idx != exp_fetch) begin
            fails++;
            $display("FAIL R11: actual=%0d expected=%0d fetches", src_idx, exp_fetch);
        end
    endtask

    task automatic load_src(input int at, input logic [7:0] v);
        src_mem[at] = v;
    endtask

    initial begin
        for (int k = 0; k < 256; k++) begin
            stuck[k]  = 8'h00;
            shadow[k] = 8'hFF;
        end
        for (int k = 0; k < 64; k++) src_mem[k] = 8'h00;
        stuck[8'h22] = 8'h04;
        // Source slices in fetch order
        load_src(0, 8'h3C);  load_src(1, 8'hA5);  load_src(2, 8'h00);  load_src(3, 8'h81);
        load_src(4, 8'hF0);  load_src(5, 8'h0F);  load_src(6, 8'h5A);
        load_src(7, 8'h3C);  load_src(8, 8'hA5);  load_src(9, 8'h00);  load_src(10, 8'h81);
        load_src(11, 8'hFF);
        load_src(12, 8'h12); load_src(13, 8'h34); load_src(14, 8'h56);

        repeat (3) @(negedge clk);
        rst = 1'b0;
        repeat (4) tick();                      // R1 reset state
        run_job(8'h10, 4, 0);                   // R3/R9 clean run
        run_job(8'h40, 0, 0);                   // R10 empty run
        run_job(8'h20, 5, 0);                   // R8 stuck bit at 0x22
        idle_tag = "R12";
        repeat (5) tick();                      // R12 failure held
        run_job(8'h10, 4, 10);                  // R11 start during pulse, R2 fail cleared
        run_job(8'h11, 2, 0);                   // R8 ones over zeros at 0x11
        run_job(8'hFE, 3, 0);                   // R3 wrap across top address
        repeat (3) tick();

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL R9: actual=running expected=finished (watchdog)");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule